// File: doc/BRIEF.md
# Multicore Private Region Decoder

This block sits on a simple synchronous register port and serves the private peripheral window of a small cluster of one to four processors. It splits an 8 KiB window into fixed sub-regions and raises a one-hot select for whichever sub-block owns the accessed address. The sub-blocks are the per-processor interrupt interfaces, the timers, the watchdogs and the shared interrupt distributor. The interrupt-interface, timer and watchdog sets each have one slot that aliases "the current processor", followed by one slot for each processor that is present.

The lowest 256 bytes hold a small snoop-control register bank that the block implements itself. It contains a one-bit enable register and a read-only configuration word computed from the processor count. It also holds a status word and an invalidate register, both of which read as zero. Read data from the bank is registered, and any access to an unused word of the bank raises a one-cycle error flag.

Top module: `mpr_region`

## Requirements
- R1: After reset the enable register (word offset 0x00) reads 0. A write stores only wdata bit 0, and the register reads back with bits 31:1 as zero.
- R2: A read of offset 0x04 returns the configuration word. It has NCPU-1 in bits 3:0 and ones in bits 4 up to 4+NCPU-1, which is 0x000000F3 for NCPU=4.
- R3: Reads of offsets 0x08 and 0x0C return zero. A write to 0x0C is accepted and leaves the enable register unchanged.
- R4: An access to any word offset 0x10 to 0xFC of the bank reads zero and is ignored if a write. It also drives err high for exactly the one cycle after the access.
- R5: rdata shows the value of a bank read in the cycle after re is sampled. In any cycle after one with no bank read, rdata is zero.
- R6: An access to 0x100 + k*0x100 through 0x1FF + k*0x100, for k = 0..NCPU, raises sel_cpuif bit k. Slot 0 is the current-processor alias.
- R7: An access to 0x600 + k*0x100 through 0x61F + k*0x100 raises sel_timer bit k. An access to 0x620 + k*0x100 through 0x63F + k*0x100 raises sel_wdog bit k, for k = 0..NCPU.
- R8: An access anywhere in 0x1000 through 0x1FFF raises sel_dist.
- R9: Selects are combinational from the address and are high only while re or we is high. At most one select is high at a time. Unmapped addresses raise no select and no error.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| addr | input | 13 | Byte offset within the private window |
| wdata | input | 32 | Write data |
| we | input | 1 | Write enable |
| re | input | 1 | Read enable |
| rdata | output | 32 | Registered read data from the snoop-control bank |
| err | output | 1 | One-cycle flag for an access to an unused bank word |
| sel_cpuif | output | NCPU+1 | Interrupt-interface selects, bit 0 is the alias |
| sel_timer | output | NCPU+1 | Timer selects, bit 0 is the alias |
| sel_wdog | output | NCPU+1 | Watchdog selects, bit 0 is the alias |
| sel_dist | output | 1 | Distributor select |

## Verification
The bench writes all ones to the enable register and expects 1, so a design that keeps more bits would fail that check. It writes to the invalidate register and to an unused bank word, then reads the enable register back, which catches any decode that lets those writes reach it. It probes the first and last byte of every slot, the gap between 0x640 and 0x6FF, the region above the last timer slot, and the distributor edges. A single-cycle slip in the decode or an off-by-one slot mapping therefore moves a select to the wrong bit or lights one in a hole. An idle cycle between bank reads exposes read data that is held instead of cleared, and it also exposes an error flag that stays high longer than one cycle.

// File: rtl/mpr_pkg.sv
package mpr_pkg;
    localparam int ADDR_W = 13;
    localparam int DATA_W = 32;
    localparam int IDX_W  = 6;

    typedef struct packed {
        logic              en;
        logic [DATA_W-1:0] rdata;
        logic              err;
    } scu_state_t;
endpackage

// File: rtl/mpr_addr_decode.sv
module mpr_addr_decode #(
    parameter int NCPU = 4
) (
    input  logic [mpr_pkg::ADDR_W-1:0] addr,
    input  logic                       access,
    output logic                       hit_scu,
    output logic [NCPU:0]              sel_cpuif,
    output logic [NCPU:0]              sel_timer,
    output logic [NCPU:0]              sel_wdog,
    output logic                       sel_dist
);
    localparam logic [3:0] CPUIF_BASE = 4'h1;
    localparam logic [3:0] TIMER_BASE = 4'h6;

    logic       low_half;
    logic [3:0] page;
    logic [2:0] sub;

    assign low_half = ~addr[12];
    assign page     = addr[11:8];
    assign sub      = addr[7:5];
    assign hit_scu  = access && low_half && (page == 4'h0);
    assign sel_dist = access && addr[12];

    for (genvar k = 0; k <= NCPU; k++) begin : g_slot
        localparam logic [3:0] CP = CPUIF_BASE + 4'(k);
        localparam logic [3:0] TP = TIMER_BASE + 4'(k);
        assign sel_cpuif[k] = access && low_half && (page == CP);
        assign sel_timer[k] = access && low_half && (page == TP) && (sub == 3'd0);
        assign sel_wdog[k]  = access && low_half && (page == TP) && (sub == 3'd1);
    end
endmodule

// File: rtl/mpr_scu_regs.sv
module mpr_scu_regs #(
    parameter int NCPU = 4
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              hit,
    input  logic                              we,
    input  logic                              re,
    input  logic [mpr_pkg::IDX_W-1:0]         idx,
    input  logic [mpr_pkg::DATA_W-1:0]        wdata,
    output logic [mpr_pkg::DATA_W-1:0]        rdata,
    output logic                              err
);
    import mpr_pkg::*;

    localparam logic [DATA_W-1:0] CPU_MASK = DATA_W'((1 << NCPU) - 1);
    localparam logic [DATA_W-1:0] CFG_WORD = (CPU_MASK << 4) | DATA_W'(NCPU - 1);
    localparam logic [IDX_W-1:0]  IDX_EN   = 6'd0;
    localparam logic [IDX_W-1:0]  IDX_CFG  = 6'd1;
    localparam logic [IDX_W-1:0]  IDX_LAST = 6'd3;

    scu_state_t st_d, st_q;

    always_comb begin
        st_d       = st_q;
        st_d.rdata = '0;
        st_d.err   = hit && (we || re) && (idx > IDX_LAST);
        if (hit && we && idx == IDX_EN) begin
            st_d.en = wdata[0];
        end
        if (hit && re) begin
            case (idx)
                IDX_EN:  st_d.rdata = {{(DATA_W-1){1'b0}}, st_q.en};
                IDX_CFG: st_d.rdata = CFG_WORD;
                default: st_d.rdata = '0;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign rdata = st_q.rdata;
    assign err   = st_q.err;

    a_r3_en_kept: assert property (@(posedge clk) disable iff (!rst_n)
        (hit && we && idx != IDX_EN) |=> (st_q.en == $past(st_q.en)));
    a_r4_err_cause: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(err) |-> $past(hit && (we || re)));
    a_r5_idle_zero: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(hit && re) |-> (rdata == '0));
    a_r1_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(hit && re && idx == IDX_EN)) |-> (rdata[DATA_W-1:1] == '0));
endmodule

// File: rtl/mpr_region.sv
module mpr_region #(
    parameter int NCPU = 4
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic [12:0]                 addr,
    input  logic [31:0]                 wdata,
    input  logic                        we,
    input  logic                        re,
    output logic [31:0]                 rdata,
    output logic                        err,
    output logic [NCPU:0]               sel_cpuif,
    output logic [NCPU:0]               sel_timer,
    output logic [NCPU:0]               sel_wdog,
    output logic                        sel_dist
);
    import mpr_pkg::*;

    logic access;
    logic hit_scu;

    assign access = we || re;

    mpr_addr_decode #(.NCPU(NCPU)) u_dec (
        .addr      (addr),
        .access    (access),
        .hit_scu   (hit_scu),
        .sel_cpuif (sel_cpuif),
        .sel_timer (sel_timer),
        .sel_wdog  (sel_wdog),
        .sel_dist  (sel_dist)
    );

    mpr_scu_regs #(.NCPU(NCPU)) u_scu (
        .clk   (clk),
        .rst_n (rst_n),
        .hit   (hit_scu),
        .we    (we),
        .re    (re),
        .idx   (addr[7:2]),
        .wdata (wdata),
        .rdata (rdata),
        .err   (err)
    );

    a_r9_onehot_sel: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({sel_cpuif, sel_timer, sel_wdog, sel_dist, hit_scu}));
    a_r9_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !access |-> ({sel_cpuif, sel_timer, sel_wdog, sel_dist} == '0));
    a_r8_dist_upper: assert property (@(posedge clk) disable iff (!rst_n)
        sel_dist |-> addr[12]);
    a_r7_timer_low: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_timer != '0 || sel_wdog != '0) |-> (!addr[12] && addr[7:6] == 2'b00));
endmodule

// File: tb/mpr_region_bench.sv
module mpr_region_bench;
    localparam int NCPU = 4;
    localparam time TCLK = 10ns;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [12:0] addr = '0;
    logic [31:0] wdata = '0;
    logic we = 1'b0, re = 1'b0;
    logic [31:0] rdata;
    logic err;
    logic [NCPU:0] sel_cpuif, sel_timer, sel_wdog;
    logic sel_dist;

    int checks = 0, errors = 0;
    logic en_m = 1'b0;

    typedef struct { logic [31:0] rd; logic er; string tag; } exp_t;
    exp_t q[$];

    always #(TCLK/2) clk = ~clk;

    mpr_region #(.NCPU(NCPU)) u_mpr_region (
        .clk(clk), .rst_n(rst_n), .addr(addr), .wdata(wdata), .we(we), .re(re),
        .rdata(rdata), .err(err), .sel_cpuif(sel_cpuif), .sel_timer(sel_timer),
        .sel_wdog(sel_wdog), .sel_dist(sel_dist)
    );

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // monitor: pops the expectation pushed at the previous falling edge
    always @(posedge clk) begin
        #2;
        if (q.size() > 0) begin
            exp_t e;
            e = q.pop_front();
            chk({e.tag, " rdata"}, 64'(rdata), 64'(e.rd));
            chk({e.tag, " err"}, 64'(err), 64'(e.er));
        end
    end

    function automatic logic [4*(NCPU+1):0] model_sel(input logic [12:0] a);
        logic [NCPU:0] c = '0, t = '0, w = '0;
        int off = int'(a);
        for (int k = 0; k <= NCPU; k++) begin
            if (off >= 'h100*(k+1) && off < 'h100*(k+2)) c[k] = 1'b1;
            if (off >= 'h600+'h100*k && off < 'h620+'h100*k) t[k] = 1'b1;
            if (off >= 'h620+'h100*k && off < 'h640+'h100*k) w[k] = 1'b1;
        end
        return {c, t, w, (off >= 'h1000)};
    endfunction

    task automatic access(input logic [12:0] a, input logic [31:0] d,
                          input logic w, input logic r, input string tag);
        exp_t e;
        logic in_bank = (a < 13'h100);
        int idx = int'(a[7:2]);
        @(negedge clk);
        addr = a; wdata = d; we = w; re = r;
        e.rd = '0;
        e.er = in_bank && (w || r) && idx > 3;
        e.tag = tag;
        if (in_bank && r) begin
            if (idx == 0) e.rd = {31'b0, en_m};
            else if (idx == 1) e.rd = 32'h0000_00F3;
        end
        if (in_bank && w && idx == 0) en_m = d[0];
        q.push_back(e);
        #1;
        chk({tag, " sel"}, 64'({sel_cpuif, sel_timer, sel_wdog, sel_dist}),
            64'((w || r) ? model_sel(a) : '0));
    endtask

    task automatic probe(input logic [12:0] a, input string tag);
        access(a, '0, 1'b0, 1'b1, tag);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk("R1 reset rdata", 64'(rdata), 64'd0);
        chk("R4 reset err", 64'(err), 64'd0);
        @(negedge clk); rst_n = 1'b1;

        probe(13'h000, "R1 en after reset");
        access(13'h000, 32'hFFFF_FFFF, 1'b1, 1'b0, "R1 write ones");
        probe(13'h000, "R1 readback one");
        probe(13'h004, "R2 config word");
        probe(13'h008, "R3 status zero");
        access(13'h00C, 32'h0000_0000, 1'b1, 1'b0, "R3 invalidate write");
        probe(13'h00C, "R3 invalidate read");
        probe(13'h000, "R3 en unchanged");
        access(13'h040, 32'h0000_0000, 1'b1, 1'b0, "R4 bad write");
        probe(13'h000, "R4 en unchanged");
        probe(13'h0FC, "R4 bad read");
        access(13'h000, '0, 1'b0, 1'b0, "R5 idle");
        access(13'h000, 32'h0000_0002, 1'b1, 1'b0, "R1 write bit1 only");
        probe(13'h000, "R1 readback zero");
        probe(13'h1004, "R5 read outside bank");

        for (int k = 0; k <= NCPU; k++) begin
            probe(13'(('h100*(k+1))), "R6 cpuif first");
            probe(13'(('h100*(k+1)) + 'hFF), "R6 cpuif last");
            probe(13'(('h600 + 'h100*k)), "R7 timer first");
            probe(13'(('h61F + 'h100*k)), "R7 timer last");
            access(13'(('h620 + 'h100*k)), 32'h1, 1'b1, 1'b0, "R7 wdog first");
            probe(13'(('h63F + 'h100*k)), "R7 wdog last");
            probe(13'(('h640 + 'h100*k)), "R9 gap");
        end
        probe(13'h0B00, "R9 above timers");
        probe(13'h0FFF, "R9 below dist");
        probe(13'h1000, "R8 dist first");
        access(13'h1FFF, 32'h5, 1'b1, 1'b0, "R8 dist last");
        access(13'h1000, '0, 1'b0, 1'b0, "R9 no access");
        access(13'h0200, '0, 1'b0, 1'b0, "R9 no access cpuif");
        probe(13'h000, "R3 en after sweep");

        repeat (3) @(negedge clk);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule